// File: doc/BRIEF.md
# Debug Breakpoint and Instruction Override

This block sits on the read-data path between program memory and the fetch stage of an 8-bit microcontroller core. It gives an external debugger control over the instruction stream. Every instruction fetch address is compared against a small bank of breakpoint entries. When an armed entry matches, the byte handed to the CPU is replaced by the break opcode 0xA5.

When the CPU takes a 0xA5 byte on a fetch, the block enters debug mode and raises its acknowledge output. The byte may have been injected by a breakpoint or may have been read from memory. While in debug mode, every fetch receives the instruction byte that the debugger supplies, and breakpoint comparison is switched off. The block also holds an interrupt-mask output high so that a pending interrupt flag raises no request.

The debugger answers the acknowledge by raising its request input. When it later lowers that request, the block leaves debug mode and normal fetching from memory resumes.

Top module: `dbg_fetch_ctl`

## Requirements
- R1: After reset, `dbg_ack` and `irq_mask` are low and every breakpoint entry is disarmed, so a fetch returns `mem_rdata` unchanged.
- R2: When `fetch_strobe` is low, `cpu_rdata` equals `mem_rdata` in the same cycle, in every mode and at every address.
- R3: Outside debug mode, a fetch (`fetch_strobe` high) whose address equals the address of an armed entry returns 0xA5 on `cpu_rdata` in the same cycle.
- R4: A clock edge with `cfg_we` high loads entry `cfg_idx` (0 to 3) with address `cfg_addr` and arm bit `cfg_arm`, taking effect from the next cycle. A fetch at the address of a disarmed entry returns `mem_rdata`.
- R5: Outside debug mode, a fetch that delivers 0xA5 to the CPU raises `dbg_ack` at the next clock edge. This holds whether the byte was injected or came from memory.
- R6: While `dbg_ack` is high, every fetch returns `dbg_instr` on `cpu_rdata`.
- R7: While `dbg_ack` is high, a fetch at an armed breakpoint address returns `dbg_instr` rather than 0xA5.
- R8: Debug mode ends at the clock edge where `dbg_req` is sampled low, provided `dbg_req` has been sampled high at an earlier edge during the same debug session. A low `dbg_req` before that leaves `dbg_ack` high.
- R9: `irq_mask` is high in exactly the cycles in which `dbg_ack` is high.
- R10: After debug mode ends, fetches again return memory data, or 0xA5 when they hit an armed entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Breakpoint entry write strobe |
| cfg_idx | input | 2 | Entry selected for the write |
| cfg_addr | input | 16 | Address loaded into the entry |
| cfg_arm | input | 1 | Arm bit loaded into the entry |
| fetch_addr | input | 16 | Program-memory address of the current access |
| fetch_strobe | input | 1 | High when the current access is an instruction fetch |
| mem_rdata | input | 8 | Byte read from program memory |
| dbg_instr | input | 8 | Instruction byte supplied by the debugger |
| dbg_req | input | 1 | Debugger request / hold-in-debug input |
| cpu_rdata | output | 8 | Byte delivered to the CPU |
| dbg_ack | output | 1 | High while the core is in debug mode |
| irq_mask | output | 1 | High while interrupts must be suppressed |

## Verification
The hardest situation to reach is a debug session in which the request drops before it was ever raised, combined with fetches that hit armed entries while debug mode is active. Random request traffic tends to raise the request early and so hides the R8 ordering. A directed sequence therefore forces a break, holds the request low for several cycles, then raises and lowers it. During that sequence it fetches breakpoint addresses and a 0xA5 debugger byte. The random phase draws fetch addresses mostly from the armed addresses and their neighbours, and plants 0xA5 in memory data so that both routes into debug mode recur.

// File: rtl/dbgf_pkg.sv
package dbgf_pkg;
  localparam logic [7:0] BREAK_OP = 8'hA5;

  typedef enum logic [1:0] {
    DM_RUN   = 2'd0,
    DM_HALT  = 2'd1,
    DM_SERVE = 2'd2
  } dmode_t;

  function automatic logic is_break_op(input logic [7:0] b);
    return b == BREAK_OP;
  endfunction

  function automatic logic addr_eq(input logic [15:0] a, input logic [15:0] b);
    return a == b;
  endfunction
endpackage

// File: rtl/bp_regs.sv
module bp_regs #(
  parameter int unsigned NBP = 4,
  parameter int unsigned AW  = 16,
  parameter int unsigned IW  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [AW-1:0]     wr_addr,
  input  logic              wr_arm,
  output logic [NBP*AW-1:0] ent_addr,
  output logic [NBP-1:0]    ent_arm
);
  for (genvar i = 0; i < NBP; i++) begin : g_ent
    logic sel;
    assign sel = wr_en && (wr_idx == IW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_addr[i*AW +: AW] <= '0;
        ent_arm[i]           <= 1'b0;
      end else if (sel) begin
        ent_addr[i*AW +: AW] <= wr_addr;
        ent_arm[i]           <= wr_arm;
      end
    end
  end
endmodule

// File: rtl/bp_match.sv
module bp_match #(
  parameter int unsigned NBP = 4,
  parameter int unsigned AW  = 16
) (
  input  logic [AW-1:0]     addr,
  input  logic              enable,
  input  logic [NBP*AW-1:0] ent_addr,
  input  logic [NBP-1:0]    ent_arm,
  output logic              hit
);
  logic [NBP-1:0] hit_vec;
  for (genvar i = 0; i < NBP; i++) begin : g_cmp
    assign hit_vec[i] = ent_arm[i] && (ent_addr[i*AW +: AW] == addr);
  end
  assign hit = enable && (|hit_vec);
endmodule

// File: rtl/dbg_fsm.sv
module dbg_fsm
  import dbgf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take_break,
  input  logic dbg_req,
  output logic in_debug
);
  dmode_t st, st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      DM_RUN:   if (take_break) st_nx = DM_HALT;
      DM_HALT:  if (dbg_req)    st_nx = DM_SERVE;
      DM_SERVE: if (!dbg_req)   st_nx = DM_RUN;
      default:                  st_nx = DM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= DM_RUN;
    else        st <= st_nx;
  end

  assign in_debug = (st != DM_RUN);

  AST_BREAK_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_debug && take_break) |=> in_debug); // R5
  AST_HALT_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == DM_HALT && !dbg_req) |=> in_debug); // R8
  AST_SERVE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == DM_SERVE && !dbg_req) |=> !in_debug); // R8
endmodule

// File: rtl/dbg_fetch_ctl.sv
module dbg_fetch_ctl
  import dbgf_pkg::*;
#(
  parameter int unsigned NBP = 4,
  parameter int unsigned AW  = 16,
  parameter int unsigned DW  = 8,
  localparam int unsigned IW = (NBP > 1) ? $clog2(NBP) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [AW-1:0] cfg_addr,
  input  logic          cfg_arm,
  input  logic [AW-1:0] fetch_addr,
  input  logic          fetch_strobe,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] dbg_instr,
  input  logic          dbg_req,
  output logic [DW-1:0] cpu_rdata,
  output logic          dbg_ack,
  output logic          irq_mask
);
  logic [NBP*AW-1:0] ent_addr;
  logic [NBP-1:0]    ent_arm;
  logic              bp_hit;
  logic              in_debug;
  logic              take_break;

  bp_regs #(.NBP(NBP), .AW(AW), .IW(IW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_idx(cfg_idx),
    .wr_addr(cfg_addr), .wr_arm(cfg_arm),
    .ent_addr(ent_addr), .ent_arm(ent_arm)
  );

  bp_match #(.NBP(NBP), .AW(AW)) u_match (
    .addr(fetch_addr), .enable(fetch_strobe && !in_debug),
    .ent_addr(ent_addr), .ent_arm(ent_arm), .hit(bp_hit)
  );

  always_comb begin
    cpu_rdata = mem_rdata;
    if (fetch_strobe) begin
      if (in_debug)    cpu_rdata = dbg_instr;
      else if (bp_hit) cpu_rdata = DW'(BREAK_OP);
    end
  end

  assign take_break = fetch_strobe && !in_debug && is_break_op(8'(cpu_rdata));

  dbg_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .take_break(take_break),
    .dbg_req(dbg_req), .in_debug(in_debug)
  );

  assign dbg_ack  = in_debug;
  assign irq_mask = in_debug;

  AST_DATA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_strobe |-> cpu_rdata == mem_rdata); // R2
  AST_DBG_FEED: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_ack && fetch_strobe) |-> cpu_rdata == dbg_instr); // R6
  AST_NO_HIT_IN_DEBUG: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_ack |-> !bp_hit); // R7
  AST_MASK_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbg_ack) |-> irq_mask); // R9
endmodule

// File: tb/tb_dbg_fetch_ctl.sv
module tb_dbg_fetch_ctl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_idx;
  logic [15:0] cfg_addr;
  logic        cfg_arm;
  logic [15:0] fetch_addr;
  logic        fetch_strobe;
  logic [7:0]  mem_rdata;
  logic [7:0]  dbg_instr;
  logic        dbg_req;
  logic [7:0]  cpu_rdata;
  logic        dbg_ack;
  logic        irq_mask;

  int n_cmp = 0;
  int n_bad = 0;

  logic [15:0] m_addr [4];
  logic        m_arm  [4];
  int          m_mode;
  logic        m_seen_req;

  always #(CLK_P/2) clk = ~clk;

  dbg_fetch_ctl dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_addr(cfg_addr), .cfg_arm(cfg_arm), .fetch_addr(fetch_addr),
    .fetch_strobe(fetch_strobe), .mem_rdata(mem_rdata), .dbg_instr(dbg_instr),
    .dbg_req(dbg_req), .cpu_rdata(cpu_rdata), .dbg_ack(dbg_ack), .irq_mask(irq_mask)
  );

  function automatic logic model_hit(input logic [15:0] a);
    for (int i = 0; i < 4; i++)
      if (m_arm[i] && m_addr[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [7:0] model_byte();
    if (!fetch_strobe) return mem_rdata;
    if (m_mode != 0)   return dbg_instr;
    if (model_hit(fetch_addr)) return 8'hA5;
    return mem_rdata;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare_now();
    string t;
    if (!fetch_strobe) t = "R2";
    else if (m_mode != 0) t = model_hit(fetch_addr) ? "R7" : "R6";
    else if (model_hit(fetch_addr)) t = "R3";
    else t = "R4/R10";
    check(t, 16'(cpu_rdata), 16'(model_byte()));
    check("R5/R8 ack", 16'(dbg_ack), 16'(m_mode != 0));
    check("R9 mask", 16'(irq_mask), 16'(m_mode != 0));
  endtask

  task automatic model_edge();
    logic [7:0] b;
    b = model_byte();
    case (m_mode)
      0: if (fetch_strobe && b == 8'hA5) m_mode = 1;
      1: if (dbg_req) m_mode = 2;
      default: if (!dbg_req) m_mode = 0;
    endcase
    if (cfg_we) begin
      m_addr[cfg_idx] = cfg_addr;
      m_arm[cfg_idx]  = cfg_arm;
    end
  endtask

  task automatic cyc(input logic st, input logic [15:0] a, input logic [7:0] md,
                     input logic [7:0] di, input logic rq);
    @(negedge clk);
    cfg_we = 1'b0; fetch_strobe = st; fetch_addr = a; mem_rdata = md;
    dbg_instr = di; dbg_req = rq;
    #1;
    compare_now();
    @(posedge clk);
    model_edge();
  endtask

  task automatic wr(input logic [1:0] i, input logic [15:0] a, input logic en);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = i; cfg_addr = a; cfg_arm = en;
    fetch_strobe = 1'b0; dbg_req = 1'b0;
    #1;
    compare_now();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] pool [8];
    void'($urandom(32'd1234));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_addr = '0; cfg_arm = 1'b0;
    fetch_addr = '0; fetch_strobe = 1'b0; mem_rdata = '0; dbg_instr = '0; dbg_req = 1'b0;
    for (int i = 0; i < 4; i++) begin m_addr[i] = '0; m_arm[i] = 1'b0; end
    m_mode = 0; m_seen_req = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state, address 0 fetch not intercepted
    fetch_strobe = 1'b1; fetch_addr = 16'h0000; mem_rdata = 8'h3C; #1;
    check("R1 data", 16'(cpu_rdata), 16'h003C);
    check("R1 ack", 16'(dbg_ack), 16'h0);
    check("R1 mask", 16'(irq_mask), 16'h0);

    // R4: arm two entries, leave one disarmed
    wr(2'd0, 16'h1234, 1'b1);
    wr(2'd3, 16'hBEEF, 1'b1);
    wr(2'd1, 16'h4000, 1'b0);
    cyc(1'b1, 16'h4000, 8'h11, 8'h00, 1'b0);           // R4 disarmed entry
    cyc(1'b0, 16'h1234, 8'h22, 8'h00, 1'b0);           // R2 data read at bp
    // R3 + R5: break on entry 3
    cyc(1'b1, 16'hBEEF, 8'h33, 8'h00, 1'b0);
    // R8: request low without prior high keeps debug mode
    cyc(1'b1, 16'h0100, 8'h44, 8'h00, 1'b0);
    cyc(1'b1, 16'h1234, 8'h44, 8'h77, 1'b0);           // R7
    cyc(1'b1, 16'h0101, 8'h44, 8'hA5, 1'b1);           // R6 with 0xA5 from debugger
    cyc(1'b1, 16'h0102, 8'h44, 8'h90, 1'b1);
    cyc(1'b0, 16'h0102, 8'h55, 8'h90, 1'b0);           // R8 exit at this edge
    cyc(1'b1, 16'h1234, 8'h66, 8'h90, 1'b0);           // R10 back to break
    cyc(1'b1, 16'h0200, 8'h12, 8'h00, 1'b1);           // in halt, req high
    cyc(1'b1, 16'h0200, 8'h12, 8'h00, 1'b0);           // leave
    cyc(1'b1, 16'h0300, 8'hA5, 8'h00, 1'b0);           // R5 break from memory byte
    cyc(1'b1, 16'h0300, 8'h00, 8'h00, 1'b1);
    cyc(1'b1, 16'h0301, 8'h01, 8'h00, 1'b0);
    cyc(1'b1, 16'h0302, 8'h02, 8'h00, 1'b0);           // R10 memory data

    // random phase
    for (int k = 0; k < 4000; k++) begin
      for (int j = 0; j < 4; j++) begin
        pool[2*j]   = m_addr[j];
        pool[2*j+1] = m_addr[j] + 16'd1;
      end
      if ($urandom_range(0, 40) == 0) begin
        wr(2'($urandom_range(0, 3)), 16'($urandom_range(0, 65535)), 1'($urandom_range(0, 1)));
      end else begin
        logic [15:0] a;
        logic [7:0]  md;
        a  = ($urandom_range(0, 3) == 0) ? 16'($urandom_range(0, 65535)) : pool[$urandom_range(0, 7)];
        md = ($urandom_range(0, 15) == 0) ? 8'hA5 : 8'($urandom_range(0, 255));
        cyc(1'($urandom_range(0, 3) != 0), a, md, 8'($urandom_range(0, 255)),
            1'($urandom_range(0, 2) != 0));
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule